// File: doc/BRIEF.md
# Arithmetic Condition Code Unit

This combinational block adds or subtracts two operands and returns both the wrapped result and a 2-bit condition code. A 2-bit operation select picks one of four operations:

- unsigned (logical) add
- unsigned subtract
- two's-complement (signed) add
- signed subtract

A width control chooses between a narrow 32-bit operation and a wide 64-bit operation. The same code rules apply at both widths.

The meaning of the code depends on the kind of operation:

- **Logical operations.** Bit 0 of the code says whether the result is nonzero. Bit 1 carries the carry-out for an add, or the no-borrow flag for a subtract.
- **Signed operations.** The code reports overflow, or else the sign of the result or that it is zero.

A surrounding execution pipeline drives the operands and latches the result and code in its own stage registers.

Top module: `cc_arith_unit`

## Requirements
- R1: The result is the sum (select 00 or 10) or the difference (select 01 or 11) of the operands, wrapped modulo 2^N. N is 64 when `wide`=1 and 32 when `wide`=0. The result wraps even when overflow is reported.
- R2: For logical add (select 00), code bit 0 is 1 exactly when the result is nonzero. Code bit 1 is 1 exactly when the unsigned sum reaches 2^N, that is, when the result is below the first operand.
- R3: For logical subtract (select 01), code bit 0 is 1 exactly when the result is nonzero. Code bit 1 is 1 exactly when no borrow occurs, that is, when the first operand is not below the second.
- R4: For signed add (select 10), when both operands share a sign and the result's sign differs from it, the code is 3, whatever the result value.
- R5: For signed subtract (select 11), when the operand signs differ and the result's sign differs from the first operand's sign, the code is 3, whatever the result value.
- R6: For signed operations without overflow, the code is:
  - 0 for a zero result
  - 1 for a negative result
  - 2 for a positive result
- R7: With `wide`=0, bits 63:32 of both operands have no effect. Result bits 63:32 are zero. Every code rule uses bit 31 as the sign bit and carry out of bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| op_sel | input | 2 | 00 logical add, 01 logical subtract, 10 signed add, 11 signed subtract |
| wide | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| res | output | 64 | Wrapped result; upper half zero in 32-bit mode |
| cc | output | 2 | Condition code |

## Verification
The assertions are re-evaluated whenever the inputs settle. They check four things:

- the nonzero bit of the logical code against the result
- the carry and no-borrow bits against an unsigned comparison of the ports
- the overflow code for both signed operations, taken from operand and result signs
- the zero upper half in narrow mode

Only the bench's scenarios can show the following:

- that the wrapped result itself is arithmetically right
- that signed overflow agrees with an exact wide-range sum
- that upper operand bits are truly ignored in narrow mode

Corner operands drive those scenarios: zero, all ones, the most negative value and the largest positive value.

// File: rtl/cca_pkg.sv
package cca_pkg;
    typedef enum logic [1:0] {
        OP_LADD = 2'b00,
        OP_LSUB = 2'b01,
        OP_SADD = 2'b10,
        OP_SSUB = 2'b11
    } cca_op_e;

    localparam int unsigned CCA_CC_W = 2;
    localparam logic [1:0]  CC_OVF   = 2'd3;
endpackage

// File: rtl/cca_addsub.sv
module cca_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = full[W-1:0];
        cout  = full[W];
    end
endmodule

// File: rtl/cca_ccgen.sv
module cca_ccgen
    import cca_pkg::*;
(
    input  cca_op_e     op,
    input  logic        a_msb,
    input  logic        b_msb,
    input  logic        s_msb,
    input  logic        s_zero,
    input  logic        cout,
    output logic [1:0]  cc
);
    logic b_eff_msb;
    logic ovf;

    always_comb begin
        b_eff_msb = (op == OP_SSUB) ? ~b_msb : b_msb;
        ovf       = (a_msb == b_eff_msb) && (s_msb != a_msb);
        unique case (op)
            OP_LADD, OP_LSUB: cc = {cout, ~s_zero};
            OP_SADD, OP_SSUB: begin
                if (ovf)         cc = CC_OVF;
                else if (s_zero) cc = 2'd0;
                else if (s_msb)  cc = 2'd1;
                else             cc = 2'd2;
            end
            default: cc = 2'd0;
        endcase
    end
endmodule

// File: rtl/cc_arith_unit.sv
module cc_arith_unit
    import cca_pkg::*;
#(
    parameter int DW = 64,
    parameter int NW = 32
) (
    input  logic [63:0] opa,
    input  logic [63:0] opb,
    input  logic [1:0]  op_sel,
    input  logic        wide,
    output logic [63:0] res,
    output logic [1:0]  cc
);
    localparam int NLANE = 2;

    cca_op_e     op;
    logic        is_sub;
    logic [DW-1:0] lane_res [NLANE];
    logic [1:0]    lane_cc  [NLANE];

    always_comb begin
        op     = cca_op_e'(op_sel);
        is_sub = (op == OP_LSUB) || (op == OP_SSUB);
    end

    for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
        localparam int W = (gi == 1) ? DW : NW;
        logic [W-1:0] s;
        logic         co;

        cca_addsub #(.W(W)) u_as (
            .a    (opa[W-1:0]),
            .b    (opb[W-1:0]),
            .sub  (is_sub),
            .sum  (s),
            .cout (co)
        );

        cca_ccgen u_cc (
            .op     (op),
            .a_msb  (opa[W-1]),
            .b_msb  (opb[W-1]),
            .s_msb  (s[W-1]),
            .s_zero (s == '0),
            .cout   (co),
            .cc     (lane_cc[gi])
        );

        if (W < DW) begin : g_ext
            assign lane_res[gi] = {{(DW-W){1'b0}}, s};
        end else begin : g_full
            assign lane_res[gi] = s;
        end
    end

    always_comb begin
        res = lane_res[wide ? 1 : 0];
        cc  = lane_cc[wide ? 1 : 0];
    end
endmodule

// File: rtl/cca_chk.sv
module cca_chk (
    input logic [63:0] opa,
    input logic [63:0] opb,
    input logic [1:0]  op_sel,
    input logic        wide,
    input logic [63:0] res,
    input logic [1:0]  cc
);
    logic [63:0] am, bm, rm;
    logic        a_s, b_s, r_s;

    always_comb begin
        am  = wide ? opa : {32'd0, opa[31:0]};
        bm  = wide ? opb : {32'd0, opb[31:0]};
        rm  = wide ? res : {32'd0, res[31:0]};
        a_s = wide ? opa[63] : opa[31];
        b_s = wide ? opb[63] : opb[31];
        r_s = wide ? res[63] : res[31];
        if (!$isunknown({opa, opb, op_sel, wide, res, cc})) begin
            if (op_sel[1] == 1'b0)
                p_nonzero_bit_r2: assert (cc[0] == (rm != 64'd0))
                    else $error("nonzero bit mismatch");
            if (op_sel == 2'b00)
                p_carry_bit_r2: assert (cc[1] == (rm < am))
                    else $error("carry bit mismatch");
            if (op_sel == 2'b01)
                p_noborrow_r3: assert (cc[1] == (am >= bm))
                    else $error("no-borrow bit mismatch");
            if (op_sel == 2'b10 && a_s == b_s && r_s != a_s)
                p_add_ovf_r4: assert (cc == 2'd3)
                    else $error("signed add overflow not coded");
            if (op_sel == 2'b11 && a_s != b_s && r_s != a_s)
                p_sub_ovf_r5: assert (cc == 2'd3)
                    else $error("signed subtract overflow not coded");
            if (op_sel[1] && cc != 2'd3)
                p_sign_code_r6: assert ((cc == 2'd0) == (rm == 64'd0) && (cc == 2'd1) == r_s)
                    else $error("signed code mismatch");
            if (!wide)
                p_upper_zero_r7: assert (res[63:32] == 32'd0)
                    else $error("upper half not zero");
        end
    end
endmodule

bind cc_arith_unit cca_chk u_chk (
    .opa    (opa),
    .opb    (opb),
    .op_sel (op_sel),
    .wide   (wide),
    .res    (res),
    .cc     (cc)
);

// File: tb/sim_cc_arith_unit.sv
module sim_cc_arith_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] opa = '0, opb = '0;
    logic [1:0]  op_sel = 2'b00;
    logic        wide = 1'b0;
    logic [63:0] res;
    logic [1:0]  cc;
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cc_arith_unit u0 (
        .opa(opa), .opb(opb), .op_sel(op_sel), .wide(wide), .res(res), .cc(cc)
    );

    function automatic logic signed [65:0] sx(logic [63:0] v, logic w);
        return w ? {{2{v[63]}}, v} : {{34{v[31]}}, v[31:0]};
    endfunction

    task automatic model(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] o, input logic w,
                         output logic [63:0] er, output logic [1:0] ec);
        logic [64:0] mask, ua, ub, us;
        logic signed [65:0] sa, sb, st, lim;
        logic ovf;
        mask = w ? {1'b0, {64{1'b1}}} : {33'd0, {32{1'b1}}};
        ua = {1'b0, a} & mask;
        ub = {1'b0, b} & mask;
        if (!o[1]) begin
            us = o[0] ? (ua - ub) : (ua + ub);
            er = us[63:0] & mask[63:0];
            ec[0] = (er != 64'd0);
            ec[1] = o[0] ? (ua >= ub) : (ua + ub > mask);
        end else begin
            sa  = sx(a, w);
            sb  = sx(b, w);
            st  = o[0] ? (sa - sb) : (sa + sb);
            lim = w ? 66'sh0_8000_0000_0000_0000 : 66'sh0_0000_0000_8000_0000;
            ovf = (st >= lim) || (st < -lim);
            er  = st[63:0] & mask[63:0];
            if (ovf)          ec = 2'd3;
            else if (st == 0) ec = 2'd0;
            else if (st < 0)  ec = 2'd1;
            else              ec = 2'd2;
        end
    endtask

    task automatic run(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] o, input logic w, input string tag);
        logic [63:0] er;
        logic [1:0]  ec;
        @(negedge clk);
        opa = a; opb = b; op_sel = o; wide = w;
        model(a, b, o, w, er, ec);
        @(posedge clk);
        #5;
        total++;
        if (res !== er || cc !== ec) begin
            bad++;
            $display("FAIL %s op=%0d wide=%0d a=%h b=%h: res=%h cc=%0d expected res=%h cc=%0d",
                     tag, o, w, a, b, res, cc, er, ec);
        end
    endtask

    localparam int NCORNER = 8;
    logic [63:0] corner [NCORNER];

    initial begin
        #20000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        corner[0] = 64'd0;
        corner[1] = 64'd1;
        corner[2] = {64{1'b1}};
        corner[3] = 64'h8000_0000_0000_0000;
        corner[4] = 64'h7fff_ffff_ffff_ffff;
        corner[5] = 64'h0000_0000_8000_0000;
        corner[6] = 64'h0000_0000_7fff_ffff;
        corner[7] = 64'hffff_ffff_0000_0000;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle inputs: zero operands, logical add gives zero result, code 0 (R2)
        #5;
        total++;
        if (res !== 64'd0 || cc !== 2'd0) begin
            bad++;
            $display("FAIL R2 idle state: res=%h cc=%0d expected res=0 cc=0", res, cc);
        end
        // directed boundary cases
        run(64'hffff_ffff, 64'd1, 2'b00, 1'b0, "R2 carry to zero narrow");
        run({64{1'b1}}, 64'd1, 2'b00, 1'b1, "R2 carry to zero wide");
        run(64'd5, 64'd5, 2'b01, 1'b0, "R3 equal no borrow");
        run(64'd4, 64'd5, 2'b01, 1'b1, "R3 borrow wide");
        run(64'h7fff_ffff, 64'd1, 2'b10, 1'b0, "R4 max plus one narrow");
        run(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'b10, 1'b1, "R4 min plus min wraps to zero");
        run(64'h8000_0000, 64'd1, 2'b11, 1'b0, "R5 min minus one narrow");
        run(64'd0, 64'h8000_0000_0000_0000, 2'b11, 1'b1, "R5 zero minus min wide");
        run(64'd3, 64'd3, 2'b11, 1'b1, "R6 zero result");
        run(64'd2, 64'd7, 2'b11, 1'b0, "R6 negative result");
        run(64'hffff_ffff_ffff_fffe, 64'd5, 2'b10, 1'b1, "R6 positive result");
        run(64'habcd_0000_0000_0001, 64'h1234_0000_ffff_ffff, 2'b00, 1'b0, "R7 upper bits ignored");
        run(64'hffff_ffff_7fff_ffff, 64'h0000_0001_0000_0001, 2'b10, 1'b0, "R7 narrow sign bit 31");
        // every pair of corner values, every op and width (R1)
        for (int i = 0; i < NCORNER; i++)
            for (int j = 0; j < NCORNER; j++)
                for (int o = 0; o < 4; o++)
                    for (int w = 0; w < 2; w++)
                        run(corner[i], corner[j], 2'(o), 1'(w), "R1 corner sweep");
        // random operands (R1, R2, R3, R4, R5, R6, R7)
        for (int k = 0; k < 4000; k++)
            run({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 1'($urandom),
                "R1 random");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule